// File: doc/BRIEF.md
# Sticky 128-bit Right Shifter

This block moves a 128-bit mantissa, presented as an upper and a lower 64-bit word, toward the least significant end by an unsigned count. It is meant for the alignment and denormalization steps of a floating-point datapath, where bits that fall off the bottom must not vanish silently. Every bit that is shifted out is folded into bit 0 of the result as a sticky flag, so a later rounding stage can still tell that the value was inexact.

The count is eight bits wide, and any value is legal. Counts of 128 and above reduce the whole mantissa to a single sticky bit. The result is registered, so it appears one clock after the operands are sampled. Rounding, normalization and exponent arithmetic belong to the surrounding datapath.

Top module: `sticky_shr128`

## Requirements
- R1: A count of 0 passes both words through unchanged, and bit 0 picks up no extra sticky contribution.
- R2: For a count c from 1 to 63, the upper output is the upper input shifted right by c. The lower output is the lower input shifted right by c, with the low c bits of the upper input filling its top c positions. Bit 0 is also ORed with the OR of the c discarded lower-input bits.
- R3: For a count of exactly 64, the upper output is zero. The lower output is the upper input, with bit 0 ORed with the OR of all 64 lower-input bits.
- R4: For a count c from 65 to 127, the upper output is zero. The lower output is the upper input shifted right by c-64, with bit 0 ORed with the OR of the discarded upper-input bits and of the entire lower input.
- R5: For any count from 128 to 255, the upper output is zero. The lower output is 1 if any input bit is set, and 0 otherwise.
- R6: The sticky flag is combined with the data bit that lands in result bit 0 by OR. It never replaces that data bit: bit 0 is 1 when either the data bit or the sticky flag is 1.
- R7: A nonzero 128-bit input never produces an all-zero result, whatever the count.
- R8: Outputs are registered. A result appears on the first rising clock edge after its operands are applied. While rst is high, a rising edge clears both outputs to zero.
- R9: With only input bit 126 set (upper-word bit 62) and a count of 71, the result has only bit 55 set (lower-word bit 55), with no sticky bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| hi_in | input | 64 | Upper word of the 128-bit operand (bits 127..64) |
| lo_in | input | 64 | Lower word of the 128-bit operand (bits 63..0) |
| shamt | input | 8 | Unsigned right-shift count, 0 to 255 |
| hi_out | output | 64 | Upper word of the shifted result |
| lo_out | output | 64 | Lower word of the shifted result, sticky folded into bit 0 |

## Verification
The bench builds the block with its default parameters: 64-bit words, an 8-bit count and the output register enabled. With these values every count from 0 to 255 can be reached, so all four shift paths are exercised, along with the boundaries 63, 64, 65, 127 and 128. Single-bit operands show whether a lone discarded bit reaches the sticky flag. Dense random operands check that the data bit and the sticky flag are combined by OR in bit 0.

// File: rtl/sticky_shr_pkg.sv
package sticky_shr_pkg;
  // Which of the four shift regimes a count selects.
  typedef enum logic [1:0] {
    SHR_SMALL = 2'd0,  // count below one word
    SHR_WORD  = 2'd1,  // count exactly one word
    SHR_CROSS = 2'd2,  // count between one and two words
    SHR_SAT   = 2'd3   // count two words or more
  } shr_path_e;
endpackage

// File: rtl/sticky_shr_classify.sv
module sticky_shr_classify
  import sticky_shr_pkg::*;
#(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic [CNT_W-1:0] cnt,
  output shr_path_e        path
);
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] ONE_WORD = AW'(WORD_W);
  localparam logic [AW-1:0] TWO_WORD = AW'(2 * WORD_W);

  logic [AW-1:0] cnt_x;
  assign cnt_x = {1'b0, cnt};

  always_comb begin
    if (cnt_x >= TWO_WORD)      path = SHR_SAT;
    else if (cnt_x > ONE_WORD)  path = SHR_CROSS;
    else if (cnt_x == ONE_WORD) path = SHR_WORD;
    else                        path = SHR_SMALL;
  end
endmodule

// File: rtl/sticky_shr_lanes.sv
module sticky_shr_lanes #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic [WORD_W-1:0] hi,
  input  logic [WORD_W-1:0] lo,
  input  logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] small_hi,
  output logic [WORD_W-1:0] small_lo,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] cross_lo,
  output logic [WORD_W-1:0] sat_lo
);
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] ONE_WORD = AW'(WORD_W);
  localparam logic [AW-1:0] TWO_WORD = AW'(2 * WORD_W);

  logic [AW-1:0] cnt_x;
  logic [AW-1:0] small_back;   // left shift that exposes the bits leaving the word
  logic [AW-1:0] cross_amt;    // shift of the upper word in the cross regime
  logic [AW-1:0] cross_back;
  logic          lo_any;
  logic          hi_any;
  logic          small_stk;
  logic          cross_stk;

  assign cnt_x      = {1'b0, cnt};
  assign small_back = ONE_WORD - cnt_x;
  assign cross_amt  = cnt_x - ONE_WORD;
  assign cross_back = TWO_WORD - cnt_x;
  assign lo_any     = |lo;
  assign hi_any     = |hi;

  // Below one word: both words move, upper-word bits drop into the lower word.
  assign small_hi  = hi >> cnt_x;
  assign small_stk = |(lo << small_back);
  assign small_lo  = (lo >> cnt_x) | (hi << small_back) | {{(WORD_W-1){1'b0}}, small_stk};

  // Exactly one word: the upper word becomes the lower word.
  assign word_lo = hi | {{(WORD_W-1){1'b0}}, lo_any};

  // Between one and two words: only part of the upper word survives.
  assign cross_stk = (|(hi << cross_back)) | lo_any;
  assign cross_lo  = (hi >> cross_amt) | {{(WORD_W-1){1'b0}}, cross_stk};

  // Two words or more: only the sticky flag survives.
  assign sat_lo = {{(WORD_W-1){1'b0}}, hi_any | lo_any};
endmodule

// File: rtl/sticky_shr_outreg.sv
module sticky_shr_outreg #(
  parameter int WORD_W  = 64,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] hi_d,
  input  logic [WORD_W-1:0] lo_d,
  output logic [WORD_W-1:0] hi_q,
  output logic [WORD_W-1:0] lo_q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          hi_q <= '0;
          lo_q <= '0;
        end else begin
          hi_q <= hi_d;
          lo_q <= lo_d;
        end
      end
    end else begin : g_comb
      assign hi_q = hi_d;
      assign lo_q = lo_d;
    end
  endgenerate
endmodule

// File: rtl/sticky_shr128.sv
module sticky_shr128
  import sticky_shr_pkg::*;
#(
  parameter int WORD_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] hi_in,
  input  logic [WORD_W-1:0] lo_in,
  input  logic [CNT_W-1:0]  shamt,
  output logic [WORD_W-1:0] hi_out,
  output logic [WORD_W-1:0] lo_out
);
  localparam int AW = CNT_W + 1;
  localparam logic [AW-1:0] ONE_WORD = AW'(WORD_W);
  localparam logic [AW-1:0] TWO_WORD = AW'(2 * WORD_W);

  shr_path_e         path;
  logic [WORD_W-1:0] small_hi, small_lo, word_lo, cross_lo, sat_lo;
  logic [WORD_W-1:0] hi_d, lo_d;

  sticky_shr_classify #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_classify (
    .cnt  (shamt),
    .path (path)
  );

  sticky_shr_lanes #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_lanes (
    .hi       (hi_in),
    .lo       (lo_in),
    .cnt      (shamt),
    .small_hi (small_hi),
    .small_lo (small_lo),
    .word_lo  (word_lo),
    .cross_lo (cross_lo),
    .sat_lo   (sat_lo)
  );

  always_comb begin
    hi_d = '0;
    unique case (path)
      SHR_SMALL: begin hi_d = small_hi; lo_d = small_lo; end
      SHR_WORD:  lo_d = word_lo;
      SHR_CROSS: lo_d = cross_lo;
      default:   lo_d = sat_lo;
    endcase
  end

  sticky_shr_outreg #(.WORD_W(WORD_W), .OUT_REG(OUT_REG)) u_out (
    .clk  (clk),
    .rst  (rst),
    .hi_d (hi_d),
    .lo_d (lo_d),
    .hi_q (hi_out),
    .lo_q (lo_out)
  );

  generate
    if (OUT_REG) begin : g_chk
      // R1
      zero_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(shamt) == '0) |->
          (hi_out == $past(hi_in) && lo_out == $past(lo_in)));

      // R2
      small_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && {1'b0, $past(shamt)} < ONE_WORD) |->
          (hi_out == ($past(hi_in) >> $past(shamt))));

      // R3
      upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && {1'b0, $past(shamt)} >= ONE_WORD) |-> (hi_out == '0));

      // R5
      sat_collapse_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && {1'b0, $past(shamt)} >= TWO_WORD) |->
          (lo_out[WORD_W-1:1] == '0 && lo_out[0] == ($past(hi_in) != '0 || $past(lo_in) != '0)));

      // R7
      never_lost_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(hi_in) != '0 || $past(lo_in) != '0)) |->
          (hi_out != '0 || lo_out != '0));

      // R8
      reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (hi_out == '0 && lo_out == '0));
    end
  endgenerate
endmodule

// File: tb/sticky_shr128_test.sv
module sticky_shr128_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] hi_in = '0;
  logic [W-1:0] lo_in = '0;
  logic [7:0]   shamt = '0;
  logic [W-1:0] hi_out, lo_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sticky_shr128 uut (
    .clk(clk), .rst(rst), .hi_in(hi_in), .lo_in(lo_in),
    .shamt(shamt), .hi_out(hi_out), .lo_out(lo_out)
  );

  // Behavioural model: wide shift, then OR of everything that fell off.
  function automatic logic [127:0] model(logic [127:0] v, int c);
    logic [127:0] r;
    logic s;
    if (c >= 128) begin
      r = '0;
      r[0] = |v;
    end else begin
      r = v >> c;
      s = 1'b0;
      for (int i = 0; i < c; i++) s = s | v[i];
      r[0] = r[0] | s;
    end
    return r;
  endfunction

  function automatic string req_of(int c);
    if (c == 0)   return "R1";
    if (c < 64)   return "R2";
    if (c == 64)  return "R3";
    if (c < 128)  return "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, result is registered at the next rising
  // edge, sample at the falling edge after it.
  task automatic apply(logic [W-1:0] h, logic [W-1:0] l, int c, string req);
    hi_in = h;
    lo_in = l;
    shamt = 8'(c);
    @(negedge clk);
    check(req, {hi_out, lo_out}, model({h, l}, c));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] h, l;
    int c;
    hi_in = 64'hDEAD_BEEF_0000_FFFF;
    lo_in = 64'h1234_5678_9ABC_DEF0;
    shamt = 8'd3;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R8: reset holds outputs at zero even with live operands
    check("R8", {hi_out, lo_out}, 128'd0);
    rst = 1'b0;

    // R1: count zero passes through
    apply(64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211, 0, "R1");
    check("R1", {hi_out, lo_out}, {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3211});

    // R2 / R6: bit 0 as data only, sticky only, and both
    apply(64'h0, 64'h2, 1, "R6");
    check("R6", {hi_out, lo_out}, 128'd1);
    apply(64'h0, 64'h1, 1, "R6");
    check("R6", {hi_out, lo_out}, 128'd1);
    apply(64'h0, 64'h3, 1, "R6");
    check("R6", {hi_out, lo_out}, 128'd1);
    apply(64'h0, 64'h4, 1, "R6");
    check("R6", {hi_out, lo_out}, 128'd2);
    apply(64'hF, 64'h0, 4, "R2");
    check("R2", {hi_out, lo_out}, {64'h0, 64'hF000_0000_0000_0000});
    apply(64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000, 63, "R2");

    // R3: exactly one word
    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h0000_0000_0000_0100, 64, "R3");
    check("R3", {hi_out, lo_out}, {64'h0, 64'hAAAA_AAAA_AAAA_AAAB});
    apply(64'hAAAA_AAAA_AAAA_AAAA, 64'h0, 64, "R3");

    // R4: cross regime boundaries
    apply(64'h3, 64'h0, 65, "R4");
    check("R4", {hi_out, lo_out}, 128'd1);
    apply(64'h8000_0000_0000_0000, 64'h0, 127, "R4");
    check("R4", {hi_out, lo_out}, 128'd1);
    apply(64'h0, 64'h1, 127, "R4");
    check("R4", {hi_out, lo_out}, 128'd1);

    // R5: saturation
    apply(64'h8000_0000_0000_0000, 64'h0, 128, "R5");
    check("R5", {hi_out, lo_out}, 128'd1);
    apply(64'h0, 64'h1, 255, "R5");
    apply(64'h0, 64'h0, 200, "R5");
    check("R5", {hi_out, lo_out}, 128'd0);

    // R9: leading bit 126 down to 55
    apply(64'h4000_0000_0000_0000, 64'h0, 71, "R9");
    check("R9", {hi_out, lo_out}, {64'h0, 64'h0080_0000_0000_0000});

    // Every count with single-bit and dense operands
    for (int k = 0; k < 256; k++) begin
      apply(64'h0, 64'h1 << (k % 64), k, req_of(k));
      apply({$urandom, $urandom}, {$urandom, $urandom}, k, req_of(k));
    end

    // Random stream; R7 checked independently of the model
    for (int k = 0; k < 3000; k++) begin
      c = int'($urandom_range(0, 255));
      if (k % 3 == 0) begin
        h = (k % 2 == 0) ? (64'h1 << $urandom_range(0, 63)) : 64'h0;
        l = (k % 2 == 0) ? 64'h0 : (64'h1 << $urandom_range(0, 63));
      end else begin
        h = {$urandom, $urandom};
        l = {$urandom, $urandom};
      end
      apply(h, l, c, req_of(c));
      n_tests++;
      if ((h != 0 || l != 0) && hi_out == 0 && lo_out == 0) begin
        n_fail++;
        $display("FAIL R7: got %h expected nonzero", {hi_out, lo_out});
      end
    end

    // R8: reset clears a live result
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, "R1");
    rst = 1'b1;
    @(negedge clk);
    check("R8", {hi_out, lo_out}, 128'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule